// File: doc/BRIEF.md
# Dual-Channel Panel Pulse-Width Generator

This block drives two pulse-width-modulated lines toward a display panel, typically one for backlight brightness and one for contrast bias. Both channels run from the same source clock. Each channel has its own clock-enable prescaler, which sets how many source cycles one step lasts. The step counter behind it sweeps a fixed frame of 256 steps. A comparison against a programmed duty value decides how many of those steps drive the line high.

Each channel takes four control inputs: an enable, a force-high override, a divide setting and a duty value. The override wins over everything else. A disabled channel sits low and keeps its counters cleared, so that enabling it starts a clean frame. Divide and duty values written while a frame is running are held back until the frame ends, which means no truncated or stretched pulse ever appears. The output comes straight from a flip-flop.

Top module: `panel_pwm_dual`

## Requirements
- R1: When a channel's force-high input is 1 at a clock edge, that channel's output is 1 after that edge, whatever its enable, divide and duty inputs are.
- R2: When force-high is 0 and enable is 0 at a clock edge, the output is 0 after that edge.
- R3: When enabled and not forced, the frame is 256 steps numbered 0 to 255. The output is 1 during step k exactly when k is below the latched duty value. The output shows each step one clock after the counters enter it.
- R4: The divide input is an unsigned 8-bit value d. Each step lasts d+1 source cycles, so one frame lasts 256·(d+1) cycles and carries duty·(d+1) high cycles.
- R5: A latched duty of 0 keeps the output constantly 0. A duty of 255 gives exactly one low step per frame.
- R6: Changes to duty or divide while enabled take effect only after step 255 of the current frame ends. Until then the output follows the old values.
- R7: A clock edge with enable 0 clears the step counter and the prescaler and captures the present duty and divide inputs. The first enabled edge after that starts step 0 of a new frame.
- R8: The two channels are independent. The controls of one never change the output of the other.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | NUM_CH | Per-channel run enable |
| chan_force | input | NUM_CH | Per-channel force-high override |
| chan_div | input | NUM_CH·DIV_W | Per-channel divide setting, channel i at bits i·DIV_W upward; step length is value+1 cycles |
| chan_duty | input | NUM_CH·STEP_W | Per-channel duty in steps, channel i at bits i·STEP_W upward |
| pwm_out | output | NUM_CH | Registered pulse outputs |

## Verification
The bench builds the block with its default parameters: two channels, an 8-bit divide field and an 8-bit step counter. The full 256-step frame, the duty extremes 0 and 255 and a divide of 255 (a 65,536-cycle frame) are therefore all reached as the block really runs. Random stimulus mostly keeps divide settings small, so many frame boundaries go by. This exercises the deferred-update behaviour and the re-enable behaviour many times. One directed window at the largest divide confirms how the prescaler behaves at its top value.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    // Source selected for a channel's output register.
    typedef enum logic [1:0] {
        DRV_LOW  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_PWM  = 2'd2
    } drive_e;

    function automatic drive_e pick_drive(input logic force_hi, input logic run);
        if (force_hi)
            return DRV_HIGH;
        else if (run)
            return DRV_PWM;
        else
            return DRV_LOW;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic [DIV_W-1:0] cnt
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == ratio) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [STEP_W-1:0] duty_in,
    output logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] duty_act,
    output logic [DIV_W-1:0]  div_act
);

    localparam logic [STEP_W-1:0] STEP_LAST = '1;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } period_state_t;

    period_state_t st_d, st_q;
    logic          frame_end;

    always_comb begin
        st_d      = st_q;
        frame_end = tick && (st_q.step == STEP_LAST);
        if (!run) begin
            st_d.step = '0;
            st_d.duty = duty_in;
            st_d.div  = div_in;
        end else if (frame_end) begin
            st_d.step = '0;
            st_d.duty = duty_in;
            st_d.div  = div_in;
        end else if (tick) begin
            st_d.step = st_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign step     = st_q.step;
    assign duty_act = st_q.duty;
    assign div_act  = st_q.div;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              force_hi,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] duty,
    output logic              line
);

    import ppwm_pkg::*;

    typedef struct packed {
        logic line;
    } out_state_t;

    out_state_t st_d, st_q;
    drive_e     sel;

    always_comb begin
        st_d = st_q;
        sel  = pick_drive(force_hi, run);
        case (sel)
            DRV_HIGH: st_d.line = 1'b1;
            DRV_PWM:  st_d.line = (step < duty);
            default:  st_d.line = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign line = st_q.line;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              force_high,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [STEP_W-1:0] duty_in,
    output logic              pwm_out
);

    logic              tick;
    logic [DIV_W-1:0]  presc_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] act_duty;
    logic [DIV_W-1:0]  act_div;

    pwm_prescaler #(.DIV_W(DIV_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .ratio (act_div),
        .tick  (tick),
        .cnt   (presc_q)
    );

    pwm_period #(.DIV_W(DIV_W), .STEP_W(STEP_W)) i_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .tick     (tick),
        .div_in   (div_in),
        .duty_in  (duty_in),
        .step     (step_q),
        .duty_act (act_duty),
        .div_act  (act_div)
    );

    pwm_out_stage #(.STEP_W(STEP_W)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .force_hi (force_high),
        .step     (step_q),
        .duty     (act_duty),
        .line     (pwm_out)
    );

endmodule

// File: rtl/panel_pwm_dual.sv
module panel_pwm_dual #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        chan_en,
    input  logic [NUM_CH-1:0]        chan_force,
    input  logic [NUM_CH*DIV_W-1:0]  chan_div,
    input  logic [NUM_CH*STEP_W-1:0] chan_duty,
    output logic [NUM_CH-1:0]        pwm_out
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.DIV_W(DIV_W), .STEP_W(STEP_W)) i_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (chan_en[g]),
            .force_high (chan_force[g]),
            .div_in     (chan_div[g*DIV_W +: DIV_W]),
            .duty_in    (chan_duty[g*STEP_W +: STEP_W]),
            .pwm_out    (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              force_high,
    input logic              pwm_out,
    input logic              tick,
    input logic [STEP_W-1:0] step_q,
    input logic [DIV_W-1:0]  presc_q,
    input logic [STEP_W-1:0] act_duty,
    input logic [DIV_W-1:0]  act_div
);

    localparam logic [STEP_W-1:0] LAST = '1;

    assert_force_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_high |=> pwm_out);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_high && !enable) |=> !pwm_out);

    assert_presc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        presc_q <= act_div);

    assert_step_waits_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(step_q));

    assert_duty_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !force_high && act_duty == '0) |=> !pwm_out);

    assert_hold_settings_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(tick && step_q == LAST)) |=> ($stable(act_duty) && $stable(act_div)));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (step_q == '0 && presc_q == '0));

endmodule

bind pwm_channel pwm_channel_chk #(.DIV_W(DIV_W), .STEP_W(STEP_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .force_high (force_high),
    .pwm_out    (pwm_out),
    .tick       (tick),
    .step_q     (step_q),
    .presc_q    (presc_q),
    .act_duty   (act_duty),
    .act_div    (act_div)
);

// File: tb/test_panel_pwm_dual.sv
`timescale 1ns/100ps
module test_panel_pwm_dual;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] frc = '0;
    logic [7:0]     div_v  [NCH];
    logic [7:0]     duty_v [NCH];
    logic [NCH*8-1:0] div_bus, duty_bus;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_presc [NCH];
    int m_step  [NCH];
    int m_duty  [NCH];
    int m_div   [NCH];
    bit m_out   [NCH];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            div_bus[i*8 +: 8]  = div_v[i];
            duty_bus[i*8 +: 8] = duty_v[i];
        end
    end

    panel_pwm_dual i_panel_pwm_dual (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (en),
        .chan_force (frc),
        .chan_div   (div_bus),
        .chan_duty  (duty_bus),
        .pwm_out    (pwm_out)
    );

    function automatic int exp_high(input int duty, input int dv);
        return duty * (dv + 1);
    endfunction

    function automatic bit exp_line(input bit f, input bit e, input int st, input int du);
        if (f) return 1'b1;
        if (!e) return 1'b0;
        return st < du;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference frame model, updated on each edge from the inputs there.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                m_presc[i] = 0; m_step[i] = 0; m_duty[i] = 0; m_div[i] = 0; m_out[i] = 0;
            end else begin
                m_out[i] = exp_line(frc[i], en[i], m_step[i], m_duty[i]);
                if (!en[i]) begin
                    m_presc[i] = 0; m_step[i] = 0;
                    m_duty[i] = duty_v[i]; m_div[i] = div_v[i];
                end else if (m_presc[i] == m_div[i]) begin
                    m_presc[i] = 0;
                    if (m_step[i] == 255) begin
                        m_step[i] = 0; m_duty[i] = duty_v[i]; m_div[i] = div_v[i];
                    end else begin
                        m_step[i] = m_step[i] + 1;
                    end
                end else begin
                    m_presc[i] = m_presc[i] + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                string tag;
                if (frc[i])                      tag = "R1";
                else if (!en[i])                 tag = "R2";
                else if (m_duty[i] != duty_v[i]) tag = "R6";
                else if (i == 1)                 tag = "R8";
                else                             tag = "R3";
                check(tag, pwm_out[i], m_out[i]);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            hi += pwm_out[ch];
        end
    endtask

    task automatic fresh(input int ch, input int dv, input int du);
        en[ch] = 1'b0; frc[ch] = 1'b0;
        div_v[ch] = dv[7:0]; duty_v[ch] = du[7:0];
        cyc(1);
        en[ch] = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi;
        int dlist [4] = '{0, 1, 128, 255};
        for (int i = 0; i < NCH; i++) begin div_v[i] = 8'd0; duty_v[i] = 8'd0; end
        cyc(3);
        check("R9 reset", pwm_out, 0);
        frc = '1; en = '1; duty_v[0] = 8'd200;
        cyc(2);
        check("R9 reset held", pwm_out, 0);
        frc = '0; en = '0;
        rst_n = 1'b1;
        cyc(2);
        check("R2 idle", pwm_out, 0);

        // R3 / R5: duty sweep at divide 0, high count over one frame window
        foreach (dlist[k]) begin
            fresh(0, 0, dlist[k]);
            cyc(4);
            count_high(0, 256, hi);
            check(dlist[k] == 0 ? "R5 duty 0" : dlist[k] == 255 ? "R5 duty 255" : "R3 duty",
                  hi, exp_high(dlist[k], 0));
        end

        // R4: divide ratio stretches each step
        fresh(0, 3, 64);
        cyc(7);
        count_high(0, 1024, hi);
        check("R4 div 3", hi, exp_high(64, 3));
        fresh(0, 255, 1);
        cyc(10);
        count_high(0, 65536, hi);
        check("R4 div 255", hi, exp_high(1, 255));

        // R6: mid-frame duty change deferred to next frame
        fresh(0, 0, 50);
        cyc(20);
        duty_v[0] = 8'd200;
        cyc(40);
        check("R6 old duty holds", pwm_out[0], 0);
        cyc(256);
        check("R6 new duty after wrap", pwm_out[0], 1);

        // R7: disable mid-frame, re-enable starts at step 0
        fresh(0, 0, 128);
        cyc(200);
        en[0] = 1'b0;
        cyc(1);
        check("R2 disabled low", pwm_out[0], 0);
        en[0] = 1'b1;
        cyc(1);
        check("R7 restart step 0", pwm_out[0], 1);
        cyc(127);
        check("R7 last high step", pwm_out[0], 1);
        cyc(1);
        check("R7 first low step", pwm_out[0], 0);

        // R1: force beats disable and duty 0
        en[0] = 1'b0; frc[0] = 1'b1;
        cyc(1);
        check("R1 force while off", pwm_out[0], 1);
        fresh(0, 0, 0); frc[0] = 1'b1;
        cyc(3);
        check("R1 force over duty 0", pwm_out[0], 1);
        frc[0] = 1'b0;

        // R8: channel 1 busy while channel 0 measured
        fresh(0, 0, 128);
        cyc(4);
        fork
            count_high(0, 256, hi);
            begin
                for (int j = 0; j < 256; j++) begin
                    en[1] = $urandom_range(0, 1); frc[1] = $urandom_range(0, 1);
                    duty_v[1] = $urandom_range(0, 255); div_v[1] = $urandom_range(0, 3);
                    cyc(1);
                end
            end
        join
        check("R8 ch0 unaffected", hi, exp_high(128, 0));

        // Random phase, checked every cycle by the model
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < 120; r++) begin
            for (int i = 0; i < NCH; i++) begin
                int p = $urandom_range(0, 9);
                en[i]  = (p != 0);
                frc[i] = (p == 1);
                div_v[i] = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 3));
                case ($urandom_range(0, 4))
                    0: duty_v[i] = 8'd0;
                    1: duty_v[i] = 8'd255;
                    default: duty_v[i] = 8'($urandom_range(1, 254));
                endcase
            end
            cyc($urandom_range(1, 300));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule